// File: doc/BRIEF.md
# Single-channel DMA transfer engine

This block is one channel of a direct memory access controller. It moves data units between a peripheral-side address and a memory-side address. Each unit is one single-beat read from the source, followed by one single-beat write to the destination, on a generic request/acknowledge memory port.

Software programs four things while the channel is disabled: a control word, a unit count, a peripheral base address and a memory base address. It then sets the enable bit. In the default mode each unit waits for the peripheral's request line. In memory-to-memory mode the units run back to back. The engine raises three sticky events: transfer complete, half transfer and bus error. An interrupt output combines the events whose enable bits are set.

The remaining-count register behaves differently at the end of a run, depending on the mode. In normal mode it stops at zero and the channel goes idle. In circular mode it reloads the programmed count, and both address pointers return to their bases.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset, the control word, count, both addresses, events, interrupt and bus request all read zero. A zero control word means: disabled, peripheral-to-memory, byte sizes, no increments, normal mode, lowest priority, memory-to-memory off.
- R2: Each unit reads the source once, then writes the destination once. The source is chosen by control bit 3: 0 takes the peripheral address as source, 1 takes the memory address. Read data is cut to the source unit size before it is written with the destination unit size.
- R3: The count drops by one at each completed write. No unit starts while the count is zero, so normal mode stops at zero.
- R4: A count write is ignored while the enable bit (control bit 0) is set.
- R5: The complete event (event bit 0) is set when the count reaches zero.
- R6: When control bit 1 (memory-to-memory) is clear, a unit starts only while periph_req_i is high, and periph_ack_o pulses once for each unit. When bit 1 is set, units run without the request.
- R7: With control bit 2 (circular) set, the last unit reloads the count with its programmed value and returns both addresses to their bases, and transfers continue.
- R8: Control bit 4 enables peripheral address increment and bit 5 enables memory address increment. Each address advances by its own unit size: 1, 2 or 4 for size code 0, 1 or 2. The peripheral size is in bits 7:6 and the memory size in bits 9:8.
- R9: An acknowledged beat with bus_err_i set raises the error event (event bit 2), clears the enable bit and leaves the count unchanged.
- R10: irq_o is high exactly when a set event has its enable bit set: bit 12 for complete, bit 13 for half, bit 14 for error. A 1 on evt_clr_i clears the matching event bit, but a new event in the same cycle wins.
- R11: The half event (event bit 1) is set when the count reaches the programmed count divided by two, rounded down.
- R12: Peripheral and memory address writes are ignored while the channel is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 15 | Control word |
| cnt_we_i | input | 1 | Count write strobe |
| cnt_wdata_i | input | CNT_W | Programmed unit count |
| paddr_we_i | input | 1 | Peripheral base address write strobe |
| maddr_we_i | input | 1 | Memory base address write strobe |
| addr_wdata_i | input | ADDR_W | Address write data |
| evt_clr_i | input | 3 | Event clear mask |
| periph_req_i | input | 1 | Peripheral request |
| periph_ack_o | output | 1 | One pulse for each completed unit |
| bus_req_o | output | 1 | Beat request, held until acknowledge |
| bus_we_o | output | 1 | 1 = write beat |
| bus_addr_o | output | ADDR_W | Beat address |
| bus_size_o | output | 2 | Beat size code |
| bus_wdata_o | output | 32 | Write data |
| bus_rdata_i | input | 32 | Read data |
| bus_ack_i | input | 1 | Beat acknowledge |
| bus_err_i | input | 1 | Error response, valid with acknowledge |
| ctrl_o | output | 15 | Current control word |
| cnt_o | output | CNT_W | Remaining count |
| paddr_o | output | ADDR_W | Current peripheral address |
| maddr_o | output | ADDR_W | Current memory address |
| evt_o | output | 3 | Events: complete, half, error |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the engine with ADDR_W = 16 and CNT_W = 8. A 256-byte bench memory then covers every legal address, and any address at or above 256 answers with an error response. This makes the error path reachable just by programming an out-of-range base. The small count width keeps the odd-count half point, circular reloads and mixed-size address stepping within a few dozen cycles.

// File: rtl/dma_ch_pkg.sv
package dma_ch_pkg;
  localparam int CTRL_W = 15;
  localparam int DATA_W = 32;
  localparam int EVT_W  = 3;
  localparam int CB_EN   = 0;
  localparam int CB_M2M  = 1;
  localparam int CB_CIRC = 2;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_RSVD = 2'd3} unit_size_e;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} seq_state_e;

  typedef struct packed {
    logic       ie_err;
    logic       ie_half;
    logic       ie_done;
    logic [1:0] prio;
    unit_size_e msize;
    unit_size_e psize;
    logic       minc;
    logic       pinc;
    logic       dir;
    logic       circ;
    logic       m2m;
    logic       en;
  } ctrl_t;

  function automatic logic [2:0] size_step(unit_size_e s);
    case (s)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] size_mask(unit_size_e s);
    case (s)
      SZ_BYTE: return DATA_W'(32'h0000_00ff);
      SZ_HALF: return DATA_W'(32'h0000_ffff);
      default: return '1;
    endcase
  endfunction
endpackage

// File: rtl/dma_ch_ctrl_regs.sv
module dma_ch_ctrl_regs import dma_ch_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              cnt_we_i,
  input  logic [CNT_W-1:0]  cnt_wdata_i,
  input  logic              unit_done_i,
  input  logic              abort_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              cnt_zero_o,
  output logic              half_hit_o,
  output logic              done_hit_o,
  output logic              wrap_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] cnt_q, reload_q, cnt_dec;

  assign cnt_dec    = cnt_q - 1'b1;
  assign done_hit_o = unit_done_i && (cnt_dec == '0);
  assign half_hit_o = unit_done_i && (cnt_dec == (reload_q >> 1));
  assign wrap_o     = done_hit_o && ctrl_q.circ;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      if (ctrl_we_i) ctrl_q <= ctrl_t'(ctrl_wdata_i);
      if (abort_i)   ctrl_q.en <= 1'b0;  // error beats any write
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      reload_q <= '0;
    end else if (cnt_we_i && !ctrl_q.en) begin
      cnt_q    <= cnt_wdata_i;
      reload_q <= cnt_wdata_i;
    end else if (unit_done_i) begin
      cnt_q <= wrap_o ? reload_q : cnt_dec;
    end
  end

  assign ctrl_o     = ctrl_q;
  assign cnt_o      = cnt_q;
  assign cnt_zero_o = (cnt_q == '0);
endmodule

// File: rtl/dma_ch_addr_ptr.sv
module dma_ch_addr_ptr import dma_ch_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic              lock_i,
  input  logic              step_i,
  input  unit_size_e        size_i,
  input  logic              rewind_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base_q, cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cur_q  <= '0;
    end else if (wr_i && !lock_i) begin
      base_q <= wdata_i;
      cur_q  <= wdata_i;
    end else if (rewind_i) begin
      cur_q <= base_q;
    end else if (step_i) begin
      cur_q <= cur_q + ADDR_W'(size_step(size_i));
    end
  end

  assign addr_o = cur_q;
endmodule

// File: rtl/dma_ch_seq.sv
module dma_ch_seq import dma_ch_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              m2m_i,
  input  logic              dir_i,
  input  unit_size_e        psize_i,
  input  unit_size_e        msize_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [ADDR_W-1:0] maddr_i,
  input  logic              cnt_zero_i,
  input  logic              periph_req_i,
  input  logic              bus_ack_i,
  input  logic              bus_err_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [1:0]        bus_size_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              unit_done_o,
  output logic              abort_o
);
  seq_state_e        st_q, st_d;
  logic [DATA_W-1:0] data_q;
  unit_size_e        src_sz, dst_sz;
  logic [ADDR_W-1:0] src_addr, dst_addr;
  logic              start, beat_ok;

  assign src_sz   = dir_i ? msize_i : psize_i;
  assign dst_sz   = dir_i ? psize_i : msize_i;
  assign src_addr = dir_i ? maddr_i : paddr_i;
  assign dst_addr = dir_i ? paddr_i : maddr_i;
  assign start    = en_i && !cnt_zero_i && (m2m_i || periph_req_i);
  assign beat_ok  = bus_ack_i && !bus_err_i;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (start) st_d = ST_RD;
      ST_RD:   if (bus_ack_i) st_d = bus_err_i ? ST_IDLE : ST_WR;
      ST_WR:   if (bus_ack_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      data_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_RD && beat_ok) data_q <= bus_rdata_i & size_mask(src_sz);
    end
  end

  assign bus_req_o   = (st_q != ST_IDLE);
  assign bus_we_o    = (st_q == ST_WR);
  assign bus_addr_o  = bus_we_o ? dst_addr : src_addr;
  assign bus_size_o  = bus_we_o ? dst_sz : src_sz;
  assign bus_wdata_o = data_q;
  assign unit_done_o = (st_q == ST_WR) && beat_ok;
  assign abort_o     = bus_req_o && bus_ack_i && bus_err_i;
endmodule

// File: rtl/dma_ch_events.sv
module dma_ch_events #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] ie_i,
  output logic [N-1:0] flag_o,
  output logic         irq_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[g]) q <= 1'b1;
      else if (clr_i[g]) q <= 1'b0;
    end
    assign flag_o[g] = q;
  end

  assign irq_o = |(flag_o & ie_i);
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine import dma_ch_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [14:0]       ctrl_wdata_i,
  input  logic              cnt_we_i,
  input  logic [CNT_W-1:0]  cnt_wdata_i,
  input  logic              paddr_we_i,
  input  logic              maddr_we_i,
  input  logic [ADDR_W-1:0] addr_wdata_i,
  input  logic [2:0]        evt_clr_i,
  input  logic              periph_req_i,
  output logic              periph_ack_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [1:0]        bus_size_o,
  output logic [31:0]       bus_wdata_o,
  input  logic [31:0]       bus_rdata_i,
  input  logic              bus_ack_i,
  input  logic              bus_err_i,
  output logic [14:0]       ctrl_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [ADDR_W-1:0] paddr_o,
  output logic [ADDR_W-1:0] maddr_o,
  output logic [2:0]        evt_o,
  output logic              irq_o
);
  localparam int NSIDE = 2;  // 0: peripheral, 1: memory

  ctrl_t             ctrl;
  logic              cnt_zero, half_hit, done_hit, wrap, unit_done, abort;
  logic [NSIDE-1:0]  side_wr, side_inc;
  unit_size_e        side_size [NSIDE];
  logic [ADDR_W-1:0] side_addr [NSIDE];

  dma_ch_ctrl_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .ctrl_we_i, .ctrl_wdata_i, .cnt_we_i, .cnt_wdata_i,
    .unit_done_i(unit_done), .abort_i(abort), .ctrl_o(ctrl), .cnt_o,
    .cnt_zero_o(cnt_zero), .half_hit_o(half_hit), .done_hit_o(done_hit), .wrap_o(wrap)
  );

  assign side_wr      = {maddr_we_i, paddr_we_i};
  assign side_inc     = {ctrl.minc, ctrl.pinc};
  assign side_size[0] = ctrl.psize;
  assign side_size[1] = ctrl.msize;

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    dma_ch_addr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
      .clk_i, .rst_ni, .wr_i(side_wr[g]), .wdata_i(addr_wdata_i), .lock_i(ctrl.en),
      .step_i(unit_done && side_inc[g]), .size_i(side_size[g]), .rewind_i(wrap),
      .addr_o(side_addr[g])
    );
  end

  dma_ch_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i, .rst_ni, .en_i(ctrl.en), .m2m_i(ctrl.m2m), .dir_i(ctrl.dir),
    .psize_i(ctrl.psize), .msize_i(ctrl.msize), .paddr_i(side_addr[0]), .maddr_i(side_addr[1]),
    .cnt_zero_i(cnt_zero), .periph_req_i, .bus_ack_i, .bus_err_i, .bus_rdata_i,
    .bus_req_o, .bus_we_o, .bus_addr_o, .bus_size_o, .bus_wdata_o,
    .unit_done_o(unit_done), .abort_o(abort)
  );

  dma_ch_events #(.N(EVT_W)) u_evt (
    .clk_i, .rst_ni, .set_i({abort, half_hit, done_hit}), .clr_i(evt_clr_i),
    .ie_i({ctrl.ie_err, ctrl.ie_half, ctrl.ie_done}), .flag_o(evt_o), .irq_o
  );

  assign periph_ack_o = unit_done;
  assign ctrl_o       = ctrl;
  assign paddr_o      = side_addr[0];
  assign maddr_o      = side_addr[1];
endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk import dma_ch_pkg::*; #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [14:0]      ctrl_o,
  input logic [CNT_W-1:0] cnt_o,
  input logic             periph_req_i,
  input logic             bus_req_o,
  input logic             bus_we_o,
  input logic             bus_ack_i,
  input logic             bus_err_i,
  input logic [2:0]       evt_o
);
  a_r3_no_beat_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && ctrl_o[CB_EN] |-> cnt_o != '0);

  a_r6_paced_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_req_o) |-> $past(ctrl_o[CB_M2M]) || $past(periph_req_i));

  a_r4_cnt_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ctrl_o[CB_EN]) && !$past(bus_req_o && bus_we_o && bus_ack_i) |-> $stable(cnt_o));

  a_r9_err_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_ack_i && bus_err_i |=> !ctrl_o[CB_EN] && evt_o[2]);

  a_r5_done_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_o[0]) |-> (cnt_o == '0) || ctrl_o[CB_CIRC]);
endmodule

bind dma_chan_engine dma_chan_engine_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_o(ctrl_o), .cnt_o(cnt_o),
  .periph_req_i(periph_req_i), .bus_req_o(bus_req_o), .bus_we_o(bus_we_o),
  .bus_ack_i(bus_ack_i), .bus_err_i(bus_err_i), .evt_o(evt_o)
);

// File: tb/dma_chan_engine_tb_top.sv
module dma_chan_engine_tb_top;
  localparam int AW = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctrl_we = 0, cnt_we = 0, paddr_we = 0, maddr_we = 0, preq = 0;
  logic [14:0]   ctrl_wd = '0;
  logic [CW-1:0] cnt_wd = '0;
  logic [AW-1:0] addr_wd = '0;
  logic [2:0]    evt_clr = '0;
  logic          pack, bus_req, bus_we, irq;
  logic [AW-1:0] bus_addr, paddr, maddr;
  logic [1:0]    bus_size;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata = '0;
  logic          bus_ack = 0, bus_err = 0;
  logic [14:0]   ctrl;
  logic [CW-1:0] cnt;
  logic [2:0]    evt;
  logic [7:0]    mem [256];
  int            n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  dma_chan_engine #(.ADDR_W(AW), .CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd),
    .cnt_we_i(cnt_we), .cnt_wdata_i(cnt_wd), .paddr_we_i(paddr_we), .maddr_we_i(maddr_we),
    .addr_wdata_i(addr_wd), .evt_clr_i(evt_clr), .periph_req_i(preq), .periph_ack_o(pack),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr), .bus_size_o(bus_size),
    .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata), .bus_ack_i(bus_ack), .bus_err_i(bus_err),
    .ctrl_o(ctrl), .cnt_o(cnt), .paddr_o(paddr), .maddr_o(maddr), .evt_o(evt), .irq_o(irq)
  );

  // memory model: one-cycle acknowledge, addresses >= 256 answer with error
  always @(posedge clk) begin
    if (!rst_n) begin
      bus_ack <= 1'b0;
      bus_err <= 1'b0;
    end else begin
      bus_ack <= 1'b0;
      bus_err <= 1'b0;
      if (bus_req && !bus_ack) begin
        bus_ack <= 1'b1;
        if (bus_addr[15:8] != 0) bus_err <= 1'b1;
        else if (bus_we) begin
          for (int k = 0; k < (bus_size == 0 ? 1 : bus_size == 1 ? 2 : 4); k++)
            mem[(int'(bus_addr[7:0]) + k) % 256] <= bus_wdata[8*k +: 8];
        end else begin
          for (int k = 0; k < 4; k++)
            bus_rdata[8*k +: 8] <= mem[(int'(bus_addr[7:0]) + k) % 256];
        end
      end
    end
  end

  function automatic logic [14:0] mk(bit en, bit m2m, bit circ, bit dir, bit pinc, bit minc,
                                     logic [1:0] psz, logic [1:0] msz, logic [2:0] ie);
    return {ie, 2'b00, msz, psz, minc, pinc, dir, circ, m2m, en};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic wr_ctrl(logic [14:0] v);
    @(negedge clk); ctrl_we = 1; ctrl_wd = v;
    @(negedge clk); ctrl_we = 0;
  endtask

  task automatic wr_cnt(logic [CW-1:0] v);
    @(negedge clk); cnt_we = 1; cnt_wd = v;
    @(negedge clk); cnt_we = 0;
  endtask

  task automatic wr_addr(logic [AW-1:0] pa, logic [AW-1:0] ma);
    @(negedge clk); paddr_we = 1; addr_wd = pa;
    @(negedge clk); paddr_we = 0; maddr_we = 1; addr_wd = ma;
    @(negedge clk); maddr_we = 0;
  endtask

  task automatic clr_evt(logic [2:0] m);
    @(negedge clk); evt_clr = m;
    @(negedge clk); evt_clr = 0;
  endtask

  task automatic wait_evt(int idx, string req);
    int n = 0;
    while (evt[idx] !== 1'b1 && n < 200) begin @(negedge clk); n++; end
    chk(req, "event reached", {31'b0, evt[idx]}, 32'd1);
  endtask

  // one peripheral-paced unit
  task automatic do_unit(string req);
    int n = 0;
    @(negedge clk); preq = 1;
    while (pack !== 1'b1 && n < 50) begin @(negedge clk); n++; end
    chk(req, "periph_ack pulse", {31'b0, pack}, 32'd1);
    preq = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "ctrl", 32'(ctrl), 0);
    chk("R1", "cnt", 32'(cnt), 0);
    chk("R1", "paddr", 32'(paddr), 0);
    chk("R1", "maddr", 32'(maddr), 0);
    chk("R1", "evt/irq/req", {evt, irq, bus_req}, 0);
  endtask

  task automatic t_m2m_word();
    for (int i = 0; i < 16; i++) begin mem[8'h10 + i] = 8'(i * 7 + 3); mem[8'h40 + i] = 0; end
    wr_addr(16'h0010, 16'h0040);
    wr_cnt(4);
    wr_ctrl(mk(1, 1, 0, 0, 1, 1, 2, 2, 3'b001));
    wait_evt(0, "R5");
    for (int i = 0; i < 16; i++) chk("R2", "word copy", 32'(mem[8'h40 + i]), 32'(i * 7 + 3));
    chk("R3", "cnt at end", 32'(cnt), 0);
    chk("R8", "paddr word step", 32'(paddr), 32'h20);
    chk("R8", "maddr word step", 32'(maddr), 32'h50);
    chk("R11", "half and done", 32'(evt), 3);
    chk("R10", "irq done enabled", 32'(irq), 1);
    mem[8'h40] = 8'hee;
    repeat (8) @(negedge clk);
    chk("R3", "no beat after zero", 32'(mem[8'h40]), 32'hee);
    wr_cnt(9);
    chk("R4", "cnt write while enabled", 32'(cnt), 0);
    wr_addr(16'h0099, 16'h0099);
    chk("R12", "paddr write while enabled", 32'(paddr), 32'h20);
    chk("R12", "maddr write while enabled", 32'(maddr), 32'h50);
    wr_ctrl(0);
    clr_evt(3'b111);
    chk("R10", "cleared irq", {evt, irq}, 0);
    wr_cnt(9);
    chk("R4", "cnt write while disabled", 32'(cnt), 9);
  endtask

  task automatic t_circ_paced();
    logic [7:0] pat [3] = '{8'ha1, 8'hb2, 8'hc3};
    int acks = 0;
    for (int i = 0; i < 3; i++) mem[8'h60 + i] = pat[i];
    wr_addr(16'h0080, 16'h0060);
    wr_cnt(3);
    wr_ctrl(mk(1, 0, 1, 1, 0, 1, 0, 0, 3'b000));
    begin
      int seen = 0;
      for (int i = 0; i < 8; i++) begin @(negedge clk); if (bus_req) seen++; end
      chk("R6", "no beat without request", 32'(seen), 0);
    end
    for (int u = 0; u < 4; u++) begin
      do_unit("R6");
      acks++;
      chk("R2", "mem to periph byte", 32'(mem[8'h80]), 32'(pat[u % 3]));
      if (u == 2) begin
        chk("R7", "cnt reload", 32'(cnt), 3);
        chk("R7", "maddr rewind", 32'(maddr), 32'h60);
        chk("R5", "done in circular", 32'(evt[0]), 1);
      end
    end
    chk("R7", "continues after wrap", 32'(cnt), 2);
    chk("R6", "units acknowledged", 32'(acks), 4);
    wr_ctrl(0);
    clr_evt(3'b111);
  endtask

  task automatic t_sizes();
    for (int i = 0; i < 8; i++) mem[8'h20 + i] = 8'(8'h51 + i);
    wr_addr(16'h0020, 16'h0090);
    wr_cnt(3);
    wr_ctrl(mk(1, 1, 0, 0, 1, 1, 1, 0, 3'b000));
    wait_evt(0, "R5");
    for (int i = 0; i < 3; i++) chk("R2", "half to byte", 32'(mem[8'h90 + i]), 32'(8'h51 + 2 * i));
    chk("R8", "paddr half step", 32'(paddr), 32'h26);
    chk("R8", "maddr byte step", 32'(maddr), 32'h93);
    wr_ctrl(0);
    clr_evt(3'b111);
  endtask

  task automatic t_error();
    wr_addr(16'h0100, 16'h0040);
    wr_cnt(2);
    wr_ctrl(mk(1, 1, 0, 0, 1, 1, 0, 0, 3'b100));
    wait_evt(2, "R9");
    chk("R9", "enable cleared", 32'(ctrl[0]), 0);
    chk("R9", "cnt unchanged", 32'(cnt), 2);
    chk("R9", "only error event", 32'(evt), 4);
    chk("R10", "irq error enabled", 32'(irq), 1);
    wr_ctrl(0);
    chk("R10", "irq masked", {evt, irq}, {3'b100, 1'b0});
    clr_evt(3'b100);
    chk("R10", "error cleared", 32'(evt), 0);
  endtask

  task automatic t_half_odd();
    mem[8'h30] = 8'h77;
    wr_addr(16'h0030, 16'h0031);
    wr_cnt(5);
    wr_ctrl(mk(1, 0, 0, 0, 0, 0, 0, 0, 3'b010));
    for (int u = 1; u <= 5; u++) begin
      do_unit("R6");
      chk("R3", "cnt decrement", 32'(cnt), 32'(5 - u));
      chk("R11", "half flag", 32'(evt[1]), (u >= 3) ? 1 : 0);
    end
    chk("R5", "done flag", 32'(evt[0]), 1);
    chk("R2", "byte copy", 32'(mem[8'h31]), 32'h77);
    begin
      int seen = 0;
      @(negedge clk); preq = 1;
      for (int i = 0; i < 8; i++) begin @(negedge clk); if (bus_req) seen++; end
      preq = 0;
      chk("R3", "stopped at zero", 32'(seen), 0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_m2m_word();
    t_circ_paced();
    t_sizes();
    t_error();
    t_half_odd();
    summary();
  end
endmodule